// File: doc/BRIEF.md
# Serial Flash SPI Command Front-End

This block is the slave side of a serial flash device model. A host frames every operation with an active-low chip select. It shifts in an opcode and then any address and data bytes on the serial input. Read data returns on a serial output that has its own output-enable, so the pad can be tri-stated. The block turns these frames into accesses on a simple byte-wide memory port. Program and erase commands pass through a write-protect filter. After a program or erase the block stays busy for a timed interval before it will accept further modifying commands. A separate device-reset pin aborts whatever is in progress.

All pins are sampled with the system clock, which must run several times faster than the serial clock. The array holds `PAGES * PAGE_BYTES` bytes and is addressed linearly. `PAGE_BYTES` is 264 by default and may be set to 256. The memory port reads combinationally. It writes one byte per `mem_wr_en` cycle and takes a one-cycle `mem_erase` strobe to clear the page that holds `mem_addr`.

Top module: `sfl_spi_front`

## Requirements
- R1: Both serial clock idle levels work (SPI modes 0 and 3). Serial input bits are taken on rising `spi_sck` and the output bit changes on falling `spi_sck`. All bytes travel MSB first.
- R2: A falling `spi_cs_n` opens a frame, and the first byte of that frame is the opcode. A rising `spi_cs_n` closes the frame. While `spi_cs_n` is high, `spi_so_oe` is 0 and activity on `spi_sck` and `spi_si` changes no state.
- R3: Opcode 0x03 is followed by 3 address bytes, most significant first, forming a linear byte address. The block then returns bytes from consecutive addresses for as long as the frame lasts, and after address `PAGES*PAGE_BYTES-1` it continues at 0.
- R4: Opcode 0x05 returns a status byte, repeated for every byte clocked. Bit 7 is ready (1 when no timed operation runs), bit 6 is protection-enabled, bit 5 is locked, and bits 4..0 are 0. After reset the status byte is 0x80.
- R5: Opcode 0x02 is followed by 3 address bytes and then data bytes. Each data byte is written to the memory at the next consecutive address. When the frame closes after at least one accepted byte, the block is busy for `BUSY_CYCLES` clocks.
- R6: Opcode 0x20 is followed by 3 address bytes. When the frame closes, `mem_erase` pulses for one cycle with `mem_addr` holding that address, which clears its page, and a busy interval starts.
- R7: If `wp_n` is 0 when a program, erase or protection-register-write (0xF1) command is issued, the command has no effect and starts no busy interval.
- R8: With `wp_n` at 0, enable-protection (0x3D) and lock (0x7F) are still carried out when the frame closes.
- R9: Opcode 0xF1 plus one data byte writes the protection register, and 0x32 reads it back. When protection is enabled, set bit k refuses program and erase at addresses whose top 3 address bits equal k. Once locked, further writes to the register are refused.
- R10: While busy, program, erase, protection-register-write, enable-protection and lock commands are ignored. Status and read still work.
- R11: `dev_reset_n` low aborts the current frame, turns off `spi_so_oe` and ends any busy interval. The block remains idle while the pin stays low. A new frame needs a fresh falling `spi_cs_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Output enable for `spi_so` |
| wp_n | input | 1 | Active-low hardware write protect |
| dev_reset_n | input | 1 | Active-low device reset pin, abort |
| mem_addr | output | ADDR_W | Byte address to the memory |
| mem_rd_data | input | 8 | Combinational read data at `mem_addr` |
| mem_wr_en | output | 1 | Write strobe for one byte |
| mem_wr_data | output | 8 | Byte to write |
| mem_erase | output | 1 | One-cycle page erase strobe |

## Verification
A rising serial clock is seen on the first clock edge after it arrives. An output byte is fetched on the following clock, and its first bit goes out on the next falling serial clock. The bench therefore holds each serial clock level for four system clocks and samples `spi_so` just before raising the serial clock, once the value has settled. Busy begins on the second clock after chip select rises, so a status frame issued right after a program or erase must read ready as 0. The bench then waits well beyond `BUSY_CYCLES` before it expects ready again. Effects on memory are checked through later read frames and a bench-side shadow of the expected array.

// File: rtl/sfl_pkg.sv
// Shared opcodes and frame phases for the serial flash front-end.
package sfl_pkg;
    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_OPC  = 3'd1,
        PH_ADDR = 3'd2,
        PH_DATA = 3'd3,
        PH_SKIP = 3'd4
    } phase_t;

    localparam logic [7:0] OP_READ  = 8'h03;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_ERASE = 8'h20;
    localparam logic [7:0] OP_STAT  = 8'h05;
    localparam logic [7:0] OP_PEN   = 8'h3D;
    localparam logic [7:0] OP_LOCK  = 8'h7F;
    localparam logic [7:0] OP_PWR   = 8'hF1;
    localparam logic [7:0] OP_PRD   = 8'h32;
endpackage

// File: rtl/sfl_pin_sampler.sv
// Registers the serial clock and chip select once and reports their edges.
// Assumes the pins are already synchronous to clk and each level lasts at
// least two clk cycles.
module sfl_pin_sampler (
    input  logic clk,
    input  logic rst_n,
    input  logic spi_sck,
    input  logic spi_cs_n,
    output logic sck_rise,
    output logic sck_fall,
    output logic cs_fall,
    output logic cs_rise
);
    logic sck_q;
    logic cs_q;

    // previous pin levels; during reset track sck so no false edge follows
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= spi_sck;
            cs_q  <= 1'b1;
        end else begin
            sck_q <= spi_sck;
            cs_q  <= spi_cs_n;
        end
    end

    assign sck_rise = spi_sck & ~sck_q;
    assign sck_fall = ~spi_sck & sck_q;
    assign cs_fall  = ~spi_cs_n & cs_q;
    assign cs_rise  = spi_cs_n & ~cs_q;
endmodule

// File: rtl/sfl_busy_timer.sv
// Self-timed busy interval: busy for CYCLES clocks after a start pulse.
// An abort clears the interval at once.
module sfl_busy_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic abort,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt;

    // remaining busy cycles
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (abort)      cnt <= '0;
        else if (start)      cnt <= CW'(CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R5
    AST_ABORT_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !busy); // R11
endmodule

// File: rtl/sfl_tx_shifter.sv
// Output shift register: a byte is loaded between falling edges and leaves
// MSB first, one bit on each falling serial clock.
module sfl_tx_shifter (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       load,
    input  logic [7:0] din,
    input  logic       shift,
    output logic       so
);
    logic [7:0] sh;

    // shift on falling serial clock, otherwise accept a new byte
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            sh <= '0;
            so <= 1'b0;
        end else if (shift) begin
            so <= sh[7];
            sh <= {sh[6:0], 1'b0};
        end else if (load) begin
            sh <= din;
        end
    end

    AST_SO_ONLY_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift && !clear) |=> $stable(so)); // R1
endmodule

// File: rtl/sfl_spi_front.sv
// Slave-side serial flash command front-end. It decodes opcode, address and
// data bytes framed by chip select, drives read and status data on a
// tri-stateable output, filters modifying commands through write protect,
// the protection register and the busy timer, and aborts on the device-reset
// pin. Assumes SCK levels of at least two clk cycles, chip-select edges at
// least two clk cycles away from SCK edges, and a combinational memory read.
module sfl_spi_front #(
    parameter int PAGES       = 4096,
    parameter int PAGE_BYTES  = 264,
    parameter int BUSY_CYCLES = 2000,
    localparam int TOTAL      = PAGES * PAGE_BYTES,
    localparam int ADDR_W     = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_si,
    output logic              spi_so,
    output logic              spi_so_oe,
    input  logic              wp_n,
    input  logic              dev_reset_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rd_data,
    output logic              mem_wr_en,
    output logic [7:0]        mem_wr_data,
    output logic              mem_erase
);
    import sfl_pkg::*;

    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(TOTAL - 1);

    logic sck_rise, sck_fall, cs_fall, cs_rise;
    phase_t            phase;
    logic [7:0]        opc, rx, byte_in, tx_din;
    logic [2:0]        bit_cnt;
    logic [1:0]        addr_cnt;
    logic [ADDR_W-1:0] addr, addr_nxt, addr_inc;
    logic [2:0]        region;
    logic              cmd_ok, wrote, load_pend, wr_en_q, erase_q;
    logic              busy, start_busy, byte_done;
    logic              prot_en, locked;
    logic [7:0]        prot_reg;

    sfl_pin_sampler u_pins (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
        .sck_rise(sck_rise), .sck_fall(sck_fall), .cs_fall(cs_fall), .cs_rise(cs_rise)
    );

    sfl_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(start_busy), .abort(!dev_reset_n), .busy(busy)
    );

    // next byte for the output shifter, chosen by the current opcode
    always_comb begin
        case (opc)
            OP_STAT: tx_din = {~busy, prot_en, locked, 5'b0};
            OP_PRD:  tx_din = prot_reg;
            default: tx_din = mem_rd_data;
        endcase
    end

    sfl_tx_shifter u_tx (
        .clk(clk), .rst_n(rst_n), .clear(cs_fall), .load(load_pend), .din(tx_din),
        .shift(sck_fall && phase != PH_IDLE), .so(spi_so)
    );

    assign byte_in   = {rx[6:0], spi_si};
    assign addr_nxt  = {addr[ADDR_W-9:0], byte_in};
    assign addr_inc  = (addr == LAST) ? '0 : addr + 1'b1;
    assign region    = addr_nxt[ADDR_W-1 -: 3];
    assign byte_done = sck_rise && (bit_cnt == 3'd7) && phase != PH_IDLE
                       && !cs_fall && !cs_rise && dev_reset_n;
    assign start_busy = cs_rise && dev_reset_n && phase == PH_DATA && cmd_ok
                        && (opc == OP_ERASE || (opc == OP_PROG && wrote));

    // frame sequencing: phase, opcode, address and memory strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE; opc <= '0; rx <= '0; bit_cnt <= '0; addr_cnt <= '0;
            addr <= '0; cmd_ok <= 1'b0; wrote <= 1'b0; load_pend <= 1'b0;
            wr_en_q <= 1'b0; mem_wr_data <= '0; erase_q <= 1'b0;
        end else if (!dev_reset_n) begin
            phase <= PH_IDLE; load_pend <= 1'b0; wr_en_q <= 1'b0; erase_q <= 1'b0;
        end else begin
            wr_en_q   <= 1'b0;
            erase_q   <= 1'b0;
            load_pend <= 1'b0;
            if (wr_en_q || (load_pend && opc == OP_READ)) addr <= addr_inc;
            if (cs_fall) begin
                phase <= PH_OPC; bit_cnt <= '0; wrote <= 1'b0; cmd_ok <= 1'b0;
            end else if (cs_rise) begin
                phase   <= PH_IDLE;
                erase_q <= start_busy && (opc == OP_ERASE);
            end else if (sck_rise && phase != PH_IDLE) begin
                bit_cnt <= bit_cnt + 3'd1;
                rx      <= byte_in;
                if (bit_cnt == 3'd7) begin
                    case (phase)
                        PH_OPC: begin
                            opc <= byte_in;
                            case (byte_in)
                                OP_READ, OP_PROG, OP_ERASE: begin
                                    phase <= PH_ADDR; addr_cnt <= '0;
                                end
                                OP_STAT, OP_PRD: begin
                                    phase <= PH_DATA; load_pend <= 1'b1;
                                end
                                OP_PEN, OP_LOCK: begin
                                    phase <= PH_DATA; cmd_ok <= !busy;
                                end
                                OP_PWR: begin
                                    phase <= PH_DATA; cmd_ok <= wp_n && !locked && !busy;
                                end
                                default: phase <= PH_SKIP;
                            endcase
                        end
                        PH_ADDR: begin
                            addr     <= addr_nxt;
                            addr_cnt <= addr_cnt + 2'd1;
                            if (addr_cnt == 2'd2) begin
                                phase     <= PH_DATA;
                                cmd_ok    <= wp_n && !busy && !(prot_en && prot_reg[region]);
                                load_pend <= (opc == OP_READ);
                            end
                        end
                        PH_DATA: begin
                            if (opc == OP_READ || opc == OP_STAT || opc == OP_PRD)
                                load_pend <= 1'b1;
                            if (opc == OP_PROG && cmd_ok) begin
                                wr_en_q <= 1'b1; mem_wr_data <= byte_in; wrote <= 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
        end
    end

    // protection state: enable and lock at frame end, register on its data byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prot_en <= 1'b0; locked <= 1'b0; prot_reg <= '0;
        end else if (dev_reset_n) begin
            if (cs_rise && phase == PH_DATA && cmd_ok) begin
                if (opc == OP_PEN)  prot_en <= 1'b1;
                if (opc == OP_LOCK) locked  <= 1'b1;
            end
            if (byte_done && phase == PH_DATA && opc == OP_PWR && cmd_ok && !locked)
                prot_reg <= byte_in;
        end
    end

    assign spi_so_oe = (phase != PH_IDLE);
    assign mem_addr  = addr;
    assign mem_wr_en = wr_en_q;
    assign mem_erase = erase_q;

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n)) |-> !spi_so_oe); // R2
    AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> !busy); // R10
    AST_RESET_PIN_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        !dev_reset_n |=> (!spi_so_oe && !mem_wr_en && !mem_erase)); // R11
    AST_LOCK_FREEZES_REG: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && $past(locked)) |-> $stable(prot_reg)); // R9
endmodule

// File: tb/sim_sfl_spi_front.sv
// Directed bench for the serial flash front-end, one task per scenario.
module sim_sfl_spi_front;
    localparam int CLK_PERIOD = 10;
    localparam int PAGES = 8;
    localparam int PB    = 264;
    localparam int TOTAL = PAGES * PB;
    localparam int AW    = $clog2(TOTAL);
    localparam int BUSY  = 1000;
    localparam int HALF  = 4;

    logic clk = 1'b0, rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, si = 1'b0, wp_n = 1'b1, drst_n = 1'b1;
    logic so, so_oe, mem_wr_en, mem_erase;
    logic [AW-1:0] mem_addr;
    logic [7:0] mem_rd_data, mem_wr_data;
    logic mode3 = 1'b0;
    logic [7:0] mem [TOTAL];
    logic [7:0] exp_mem [TOTAL];
    int checks = 0, fails = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sfl_spi_front #(.PAGES(PAGES), .PAGE_BYTES(PB), .BUSY_CYCLES(BUSY)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_cs_n(cs_n), .spi_si(si),
        .spi_so(so), .spi_so_oe(so_oe), .wp_n(wp_n), .dev_reset_n(drst_n),
        .mem_addr(mem_addr), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
        .mem_wr_data(mem_wr_data), .mem_erase(mem_erase)
    );

    function automatic logic [7:0] pat(int i);
        return 8'(i) ^ 8'hA5;
    endfunction

    initial for (int i = 0; i < TOTAL; i++) begin mem[i] = pat(i); exp_mem[i] = pat(i); end

    assign mem_rd_data = (int'(mem_addr) < TOTAL) ? mem[mem_addr] : 8'h00;
    always @(posedge clk) begin
        if (mem_wr_en) mem[mem_addr] <= mem_wr_data;
        if (mem_erase)
            for (int j = 0; j < PB; j++) mem[(int'(mem_addr) / PB) * PB + j] <= 8'hFF;
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic [7:0] tb, output logic [7:0] rb);
        for (int i = 7; i >= 0; i--) begin
            if (mode3) begin
                sck = 1'b0; si = tb[i]; wait_clk(HALF); rb[i] = so; sck = 1'b1; wait_clk(HALF);
            end else begin
                si = tb[i]; wait_clk(HALF); rb[i] = so; sck = 1'b1; wait_clk(HALF); sck = 1'b0;
            end
        end
    endtask

    task automatic cs_begin();
        sck = mode3; wait_clk(2); cs_n = 1'b0; wait_clk(HALF);
    endtask

    task automatic cs_end();
        wait_clk(HALF); cs_n = 1'b1; wait_clk(2 * HALF);
    endtask

    task automatic send_addr(int a);
        logic [7:0] d;
        xfer(8'(a >> 16), d); xfer(8'(a >> 8), d); xfer(8'(a), d);
    endtask

    task automatic get_status(output logic [7:0] s);
        logic [7:0] d;
        cs_begin(); xfer(8'h05, d); xfer(8'h00, s); cs_end();
    endtask

    task automatic read_check(int a, int n, string req);
        logic [7:0] d;
        cs_begin(); xfer(8'h03, d); send_addr(a);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, d);
            chk(req, d, exp_mem[(a + k) % TOTAL]);
        end
        cs_end();
    endtask

    task automatic prog(int a, logic [7:0] b);
        logic [7:0] d;
        cs_begin(); xfer(8'h02, d); send_addr(a); xfer(b, d); cs_end();
    endtask

    task automatic erase(int a);
        logic [7:0] d;
        cs_begin(); xfer(8'h20, d); send_addr(a); cs_end();
    endtask

    task automatic one_byte_cmd(logic [7:0] op);
        logic [7:0] d;
        cs_begin(); xfer(op, d); cs_end();
    endtask

    task automatic prot_write(logic [7:0] v);
        logic [7:0] d;
        cs_begin(); xfer(8'hF1, d); xfer(v, d); cs_end();
    endtask

    task automatic prot_read(output logic [7:0] v);
        logic [7:0] d;
        cs_begin(); xfer(8'h32, d); xfer(8'h00, v); cs_end();
    endtask

    task automatic t_reset();
        logic [7:0] s;
        chk("R2 reset oe", so_oe, 0);
        get_status(s);
        chk("R4 reset status", s, 8'h80);
    endtask

    task automatic t_reads();
        mode3 = 1'b0; read_check(16, 4, "R3 R1 mode0 read");
        mode3 = 1'b1; read_check(TOTAL - 2, 4, "R3 R1 mode3 wrap read");
        mode3 = 1'b0;
    endtask

    task automatic t_program();
        logic [7:0] s, d;
        cs_begin(); xfer(8'h02, d); send_addr(256); xfer(8'hAA, d); xfer(8'h55, d); cs_end();
        exp_mem[256] = 8'hAA; exp_mem[257] = 8'h55;
        get_status(s);
        chk("R5 busy after program", s[7], 0);
        wait_clk(BUSY + 100);
        get_status(s);
        chk("R5 ready after interval", s, 8'h80);
        read_check(255, 4, "R5 program data");
    endtask

    task automatic t_busy_ignore();
        logic [7:0] s;
        prog(288, 8'h11); exp_mem[288] = 8'h11;
        prog(304, 8'h22);
        erase(5 * PB);
        wait_clk(BUSY + 100);
        get_status(s);
        chk("R10 ready", s, 8'h80);
        read_check(288, 1, "R5 first program");
        read_check(304, 1, "R10 program while busy ignored");
        read_check(5 * PB, 2, "R10 erase while busy ignored");
    endtask

    task automatic t_erase();
        logic [7:0] s;
        erase(2 * PB + 5);
        for (int j = 0; j < PB; j++) exp_mem[2 * PB + j] = 8'hFF;
        get_status(s);
        chk("R6 busy after erase", s[7], 0);
        wait_clk(BUSY + 100);
        read_check(2 * PB - 1, 3, "R6 erase lower edge");
        read_check(3 * PB - 1, 2, "R6 erase upper edge");
    endtask

    task automatic t_wp();
        logic [7:0] s, v;
        wp_n = 1'b0;
        prog(320, 8'h33);
        get_status(s);
        chk("R7 no busy under wp", s, 8'h80);
        read_check(320, 1, "R7 program refused");
        erase(3 * PB + 8);
        get_status(s);
        chk("R7 erase no busy", s, 8'h80);
        read_check(3 * PB + 8, 1, "R7 erase refused");
        prot_write(8'hFF);
        prot_read(v);
        chk("R7 prot write refused", v, 8'h00);
        one_byte_cmd(8'h3D);
        get_status(s);
        chk("R8 enable accepted under wp", s, 8'hC0);
        wp_n = 1'b1;
    endtask

    task automatic t_prot();
        logic [7:0] s, v;
        prot_write(8'h02);
        prot_read(v);
        chk("R9 prot reg write", v, 8'h02);
        prog(600, 8'h44);
        get_status(s);
        chk("R9 protected region no busy", s, 8'hC0);
        read_check(600, 1, "R9 protected program refused");
        prog(336, 8'h66); exp_mem[336] = 8'h66;
        wait_clk(BUSY + 100);
        read_check(336, 1, "R9 unprotected region written");
        wp_n = 1'b0;
        one_byte_cmd(8'h7F);
        wp_n = 1'b1;
        get_status(s);
        chk("R8 lock accepted under wp", s, 8'hE0);
        prot_write(8'h00);
        prot_read(v);
        chk("R9 locked register kept", v, 8'h02);
    endtask

    task automatic t_reset_pin();
        logic [7:0] s, d;
        cs_begin(); xfer(8'h03, d); xfer(8'h00, d);
        drst_n = 1'b0; wait_clk(3);
        chk("R11 oe off in reset", so_oe, 0);
        drst_n = 1'b1; wait_clk(2);
        xfer(8'h00, d); xfer(8'h00, d);
        chk("R11 frame stays dead", so_oe, 0);
        cs_end();
        read_check(16, 2, "R11 recovery read");
        prog(352, 8'h77); exp_mem[352] = 8'h77;
        get_status(s);
        chk("R11 busy before abort", s[7], 0);
        drst_n = 1'b0; wait_clk(2); drst_n = 1'b1; wait_clk(2);
        get_status(s);
        chk("R11 busy cleared", s, 8'hE0);
        read_check(352, 1, "R11 byte kept");
    endtask

    task automatic t_deselect();
        logic [7:0] s;
        logic [15:0] junk = 16'h0220;
        for (int i = 15; i >= 0; i--) begin
            si = junk[i]; wait_clk(HALF); sck = 1'b1; wait_clk(HALF); sck = 1'b0;
            if (so_oe !== 1'b0) chk("R2 oe while deselected", so_oe, 0);
        end
        chk("R2 oe deselected end", so_oe, 0);
        get_status(s);
        chk("R2 no state change", s, 8'hE0);
        mode3 = 1'b1; get_status(s); mode3 = 1'b0;
        chk("R1 R4 mode3 status", s, 8'hE0);
    endtask

    initial begin
        wait_clk(5); rst_n = 1'b1; wait_clk(3);
        t_reset();
        t_reads();
        t_program();
        t_busy_ignore();
        t_erase();
        t_wp();
        t_prot();
        t_reset_pin();
        t_deselect();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL R2 watchdog: actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule